// File: doc/BRIEF.md
# Key-Sequence Windowed Watchdog

This block is a watchdog timer for a microcontroller subsystem. A 3-bit rate field picks the timeout period and a mode bit turns on windowed servicing. Software keeps the watchdog from firing by writing two key bytes to a service register through a simple write strobe. The first byte is 0x55 and it arms the sequence. A later 0xAA completes the sequence and restarts the period. Other bus cycles may fall between the two key writes.

A write of any other value, an out-of-order key, a missing restart or, in windowed mode, a write that comes too early produces a single-cycle reset request. The reset controller downstream acts on that request. The request also reloads the timer and clears any pending first key. Reads of the service register always return zero.

Top module: `key_watchdog`

## Requirements
- R1: When rate_i is 000 the watchdog is off. Writes have no effect and rst_req_o stays low.
- R2: For a nonzero rate_i = N the period P is 2^(BASE_SHIFT + STEP_SHIFT*N) clock cycles. With the defaults (3 and 1) this is 2^(3+N), so N=1 gives 16 and N=2 gives 32.
- R3: While enabled, a write of any byte other than 0x55 or 0xAA raises rst_req_o on the next clock edge.
- R4: A 0x55 write followed later by a 0xAA write restarts the period. Any number of idle or other cycles may fall between them. The next timeout then comes P edges after the 0xAA edge.
- R5: Repeated 0x55 writes before the 0xAA are legal and raise no request.
- R6: If no restart occurs, rst_req_o rises P clock edges after the last restart, request or configuration change edge.
- R7: With window_i = 1, a write of any value while fewer than 3P/4 cycles have elapsed in the period raises a request. Key writes after that point are accepted.
- R8: rd_data_o is always 0x00.
- R9: A 0xAA write with no pending 0x55 raises a request and does not restart the period.
- R10: rst_req_o is a one-cycle pulse. On a request the count restarts and any pending 0x55 is dropped, so the next timeout comes P edges later.
- R11: A change of rate_i or window_i reloads the count and drops any pending 0x55. No request is raised on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rate_i | input | 3 | Rate select, 000 disables |
| window_i | input | 1 | Windowed service mode |
| wr_en_i | input | 1 | Service register write strobe |
| wr_data_i | input | 8 | Service register write data |
| rd_data_o | output | 8 | Service register read data, always zero |
| rst_req_o | output | 1 | Single-cycle reset request |

## Verification
The bench builds the block with its default shifts, which give periods of 16 cycles at rate 1 up to 1024 at rate 7. These short periods let both timeouts and the 3P/4 window boundary be reached within a few dozen cycles. Random stimulus therefore crosses many complete periods, mixed with changes of rate and window mode. It also brings the corner where a restarting key lands on the very last cycle of a period within reach.

// File: rtl/key_wdog_pkg.sv
package key_wdog_pkg;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;
endpackage

// File: rtl/wdog_rate_decode.sv
module wdog_rate_decode #(
  parameter int RATE_W     = 3,
  parameter int BASE_SHIFT = 3,
  parameter int STEP_SHIFT = 1,
  parameter int CNT_W      = BASE_SHIFT + STEP_SHIFT * ((1 << RATE_W) - 1)
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic              en_o,
  output logic [CNT_W-1:0]  last_o,
  output logic [CNT_W-1:0]  win_o
);
  logic [CNT_W:0] period;

  always_comb begin
    period = '0;
    period[BASE_SHIFT + STEP_SHIFT * int'(rate_i)] = 1'b1;
    en_o   = (rate_i != '0);
    last_o = CNT_W'(period - 1'b1);
    win_o  = CNT_W'(period - (period >> 2));
  end

  always_comb begin
    if (en_o) AST_WIN_INSIDE: assert (win_o < last_o); // R7
  end
endmodule

// File: rtl/wdog_key_track.sv
module wdog_key_track
  import key_wdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       reload_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       window_i,
  input  logic       too_early_i,
  input  logic       expire_i,
  output logic       restart_o,
  output logic       illegal_o
);
  logic armed_q;
  logic wr, is_arm, is_fire, early;

  assign wr      = wr_en_i & en_i & ~reload_i;
  assign is_arm  = (wr_data_i == KEY_ARM);
  assign is_fire = (wr_data_i == KEY_FIRE);
  assign early   = window_i & too_early_i;

  assign restart_o = wr & is_fire & armed_q & ~early;
  assign illegal_o = wr & (~(is_arm | is_fire) | (is_fire & ~armed_q) | early);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else if (!en_i || reload_i || illegal_o || restart_o || expire_i) armed_q <= 1'b0;
    else if (wr && is_arm) armed_q <= 1'b1;
  end

  AST_ARM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !armed_q); // R4
  AST_ARM_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && wr && is_arm && !early) |-> !illegal_o); // R5
  AST_RELOAD_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> !armed_q); // R11
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             reload_i,
  input  logic             restart_i,
  input  logic             illegal_i,
  input  logic [CNT_W-1:0] last_i,
  input  logic [CNT_W-1:0] win_i,
  output logic             too_early_o,
  output logic             expire_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             fire;

  assign too_early_o = (cnt_q < win_i);
  assign expire_o    = en_i & (cnt_q == last_i);
  assign fire        = en_i & ~reload_i & (illegal_i | (expire_o & ~restart_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= fire;
      if (!en_i || reload_i || fire || restart_i) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !reload_i) |-> cnt_q <= last_i); // R2
  AST_TIMEOUT_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !reload_i && expire_o && !restart_i) |=> rst_req_o); // R6
  AST_REQ_RELOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> cnt_q == '0); // R10
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !rst_req_o); // R1
  AST_RELOAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> !rst_req_o); // R11
endmodule

// File: rtl/key_watchdog.sv
module key_watchdog #(
  parameter int RATE_W     = 3,
  parameter int BASE_SHIFT = 3,
  parameter int STEP_SHIFT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              window_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        rd_data_o,
  output logic              rst_req_o
);
  import key_wdog_pkg::*;
  localparam int CNT_W = BASE_SHIFT + STEP_SHIFT * ((1 << RATE_W) - 1);

  logic [RATE_W-1:0] rate_q;
  logic              win_q, cfg_chg, en;
  logic [CNT_W-1:0]  last, win_start;
  logic              too_early, expire, restart, illegal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0;
      win_q  <= 1'b0;
    end else begin
      rate_q <= rate_i;
      win_q  <= window_i;
    end
  end

  assign cfg_chg   = (rate_i != rate_q) | (window_i != win_q);
  assign rd_data_o = '0;

  wdog_rate_decode #(
    .RATE_W(RATE_W), .BASE_SHIFT(BASE_SHIFT), .STEP_SHIFT(STEP_SHIFT), .CNT_W(CNT_W)
  ) u_decode (
    .rate_i(rate_i), .en_o(en), .last_o(last), .win_o(win_start)
  );

  wdog_key_track u_keys (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .reload_i(cfg_chg),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .window_i(window_i),
    .too_early_i(too_early), .expire_i(expire),
    .restart_o(restart), .illegal_o(illegal)
  );

  wdog_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .reload_i(cfg_chg),
    .restart_i(restart), .illegal_i(illegal), .last_i(last), .win_i(win_start),
    .too_early_o(too_early), .expire_o(expire), .rst_req_o(rst_req_o)
  );

  AST_BAD_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !cfg_chg && wr_en_i && wr_data_i != KEY_ARM && wr_data_i != KEY_FIRE)
    |=> rst_req_o); // R3
  AST_EARLY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !cfg_chg && wr_en_i && window_i && too_early) |=> rst_req_o); // R7
  AST_LONE_FIRE_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !cfg_chg && wr_en_i && wr_data_i == KEY_FIRE && !restart) |=> rst_req_o); // R9
endmodule

// File: tb/key_watchdog_test.sv
module key_watchdog_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] rate_i = 3'd0;
  logic       window_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       rst_req_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  key_watchdog uut (
    .clk_i(clk), .rst_ni(rst_ni), .rate_i(rate_i), .window_i(window_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .rst_req_o(rst_req_o)
  );

  always #10 clk = ~clk;

  function automatic int period_of(input logic [2:0] r);
    return 1 << (3 + int'(r));
  endfunction

  function automatic int win_of(input logic [2:0] r);
    return period_of(r) - period_of(r) / 4;
  endfunction

  // reference model built from the requirements
  int   m_cnt;
  bit   m_armed, m_req, m_win;
  logic [2:0] m_rate;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_armed = 0; m_req = 0; m_rate = 0; m_win = 0;
    end else begin
      bit chg, bad, rs;
      int p;
      chg = (rate_i != m_rate) || (window_i != m_win);
      m_rate = rate_i; m_win = window_i; m_req = 0;
      if (rate_i == 0 || chg) begin
        m_cnt = 0; m_armed = 0;
      end else begin
        p = period_of(rate_i); bad = 0; rs = 0;
        if (wr_en_i) begin
          if (window_i && m_cnt < win_of(rate_i)) bad = 1;
          else if (wr_data_i == 8'h55) m_armed = 1;
          else if (wr_data_i == 8'hAA && m_armed) rs = 1;
          else bad = 1;
        end
        if (bad || (m_cnt == p - 1 && !rs)) begin
          m_req = 1; m_cnt = 0; m_armed = 0;
        end else if (rs) begin
          m_cnt = 0; m_armed = 0;
        end else m_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      check(rst_req_o == m_req, "R2/R3/R6/R7/R9 model", rst_req_o, m_req);
      check(rd_data_o == 8'h00, "R8 read zero", rd_data_o, 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic wait_req(output int n);
    n = 0;
    do begin tick(); n++; end while (!rst_req_o && n < 5000);
  endtask

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (3) tick();
    check(rst_req_o == 1'b0, "R10 reset state", rst_req_o, 0);
    check(rd_data_o == 8'h00, "R8 reset read", rd_data_o, 0);
    rst_ni = 1'b1;
    tick();

    wr(8'h13); check(rst_req_o == 1'b0, "R1 off junk", rst_req_o, 0);
    wr(8'hAA); check(rst_req_o == 1'b0, "R1 off key", rst_req_o, 0);

    rate_i = 3'd1;
    wait_req(n); check(n == 17, "R6 timeout rate1", n, 17);
    tick(); check(rst_req_o == 1'b0, "R10 pulse width", rst_req_o, 0);
    wait_req(n); check(n == 15, "R10 reload after request", n, 15);

    rate_i = 3'd2;
    wait_req(n); check(n == 33, "R2 timeout rate2", n, 33);

    repeat (5) tick();
    wr(8'h55); repeat (3) tick();
    wr(8'h55); check(rst_req_o == 1'b0, "R5 repeated arm", rst_req_o, 0);
    repeat (4) tick();
    wr(8'hAA); check(rst_req_o == 1'b0, "R4 sequence accepted", rst_req_o, 0);
    wait_req(n); check(n == 32, "R4 restart period", n, 32);

    wr(8'hAA); check(rst_req_o == 1'b1, "R9 lone AA", rst_req_o, 1);
    wr(8'h3C); check(rst_req_o == 1'b1, "R3 bad byte", rst_req_o, 1);

    wr(8'h55);
    rate_i = 3'd1; tick();
    check(rst_req_o == 1'b0, "R11 no request on change", rst_req_o, 0);
    wr(8'hAA); check(rst_req_o == 1'b1, "R11 arm dropped", rst_req_o, 1);

    window_i = 1'b1; tick();
    wr(8'h55); check(rst_req_o == 1'b1, "R7 early write", rst_req_o, 1);
    repeat (12) tick();
    wr(8'h55); check(rst_req_o == 1'b0, "R7 late arm", rst_req_o, 0);
    wr(8'hAA); check(rst_req_o == 1'b0, "R7 late fire", rst_req_o, 0);
    window_i = 1'b0;

    for (int i = 0; i < 6000; i++) begin
      int r, k;
      r = int'($urandom % 100);
      if (r < 2) rate_i = 3'($urandom % 4);
      else if (r == 2) window_i = ~window_i;
      if (r >= 10 && r < 24) begin
        k = int'($urandom % 8);
        wr_en_i = 1'b1;
        wr_data_i = (k < 4) ? 8'h55 : (k < 7) ? 8'hAA : 8'($urandom);
      end
      tick();
      wr_en_i = 1'b0;
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule